// File: doc/BRIEF.md
# Link Training Supervisor with Stuck-Recovery Kick

This block watches a serial link while it trains and decides when the link counts as established. A start request first pins the target-speed field of a speed configuration word to first-generation speed. One cycle later it turns on the training enable. From then on it checks the link status at a fixed interval. At each check it looks for one fault: a speed change that has stalled in the receiver-lock recovery state while the receiver reports no valid data. When it sees that fault, it drives two receiver override controls (data enable and PLL enable) for a fixed interval and then releases them.

A bounded number of checks is allowed. If the link never becomes established, the block raises a sticky failure flag. When the link is established, a sticky good flag is raised. Both flags hold until the next start request. The override controls are presented in two forms. One is two discrete pins. The other is a full override word, formed from the current override register contents, where only the two override bits are changed. All intervals are given in microseconds and converted to clock cycles from a clock-frequency parameter.

The controller is built around states named IDLE, SPEED, CHECK, KICK, WAIT, GOOD and FAIL. Its transitions are as follows:
- start (any state) to SPEED.
- SPEED to CHECK.
- CHECK to GOOD when the link is established.
- CHECK to KICK when recovery is stuck.
- CHECK to WAIT otherwise.
- KICK to WAIT when the kick interval expires.
- WAIT to CHECK when the poll interval expires and attempts remain.
- WAIT to FAIL when the poll interval expires on the last attempt.
- GOOD and FAIL hold until the next start.

Top module: `link_train_supervisor`

## Requirements
- R1: After reset the good flag, fail flag, training enable and both override pins are 0. `speed_cfg_o` equals `speed_cfg_i`, and `ovr_word_o` equals `ovr_base_i` with bits 5 and 3 cleared.
- R2: A start request sampled at clock edge E makes `speed_cfg_o[3:0]` equal 1 from edge E onward, with `speed_cfg_o[15:4]` following `speed_cfg_i[15:4]`. `train_en_o` is still 0 after E and rises after edge E+1.
- R3: The first check samples the inputs at edge E+2. A check that sees `link_up_i`=1 and `in_training_i`=0 raises `link_good_o` after that edge. The flag then stays high whatever the inputs do, until the next start.
- R4: A check that sees `link_up_i`=0, or `in_training_i`=1, does not raise `link_good_o`.
- R5: A check that sees `ltssm_state_i`=6'h0D and `rx_valid_i`=0, without an established link, asserts both override pins from the next cycle for exactly KICK_US microseconds of clock cycles. Both pins then drop together.
- R6: No override pulse occurs when `rx_valid_i`=1 or `ltssm_state_i` is not 6'h0D at a check.
- R7: While a pulse is active, `ovr_word_o` is `ovr_base_i` with bits 5 (data enable) and 3 (PLL enable) set. Otherwise both bits are clear. All other bits always follow `ovr_base_i`.
- R8: Consecutive checks are 1+POLL cycles apart, plus KICK cycles when a pulse was given. After MAX_TRIES unsuccessful checks and one final poll interval, `link_fail_o` rises and stays high until the next start, and `train_en_o` drops.
- R9: A start request in any state restarts the sequence. It clears the good flag, the fail flag, the override pulse and the attempt count.
- R10: `link_good_o` and `link_fail_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start (or restart) bring-up |
| link_up_i | input | 1 | Link-up status bit |
| in_training_i | input | 1 | Link-in-training status bit |
| ltssm_state_i | input | 6 | Link training state code |
| rx_valid_i | input | 1 | Receiver reports valid data |
| ovr_base_i | input | 16 | Current override register contents |
| speed_cfg_i | input | 16 | Current speed configuration word |
| train_en_o | output | 1 | Training enable |
| speed_cfg_o | output | 16 | Speed configuration word with forced target speed |
| ovr_word_o | output | 16 | Override register word to write back |
| rx_data_en_ovr_o | output | 1 | Receiver data-enable override |
| rx_pll_en_ovr_o | output | 1 | Receiver PLL-enable override |
| link_good_o | output | 1 | Link established (sticky) |
| link_fail_o | output | 1 | Attempts exhausted (sticky) |

## Verification
The supervisor is tried with the following input patterns:
- A link that is established at the first check. This measures the start-to-good latency.
- A link that is up but still training, and a link that is down. Each must run through every attempt, and the exact fail time confirms the poll spacing and the attempt budget.
- The stuck pattern (state 6'h0D with no valid receive data). This must give one pulse of exact length per attempt.
- Near-miss patterns: the stuck state with valid receive data, and a neighbouring state code without valid data. Neither may pulse.
- The stuck pattern clearing while a pulse is active, and restarts issued in the middle of polling and in the middle of a pulse. These separate pulse timing from check timing and show that the restart clears all state.

// File: rtl/lts_pkg.sv
package lts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPEED,
        ST_CHECK,
        ST_KICK,
        ST_WAIT,
        ST_GOOD,
        ST_FAIL
    } lts_state_e;

    localparam int unsigned US_PER_S = 1_000_000;

endpackage

// File: rtl/lts_status_decode.sv
module lts_status_decode #(
    parameter int unsigned       STATE_W    = 6,
    parameter logic [STATE_W-1:0] STUCK_CODE = 6'h0D
) (
    input  logic               link_up_i,
    input  logic               in_training_i,
    input  logic [STATE_W-1:0] ltssm_state_i,
    input  logic               rx_valid_i,
    output logic               up_ok_o,
    output logic               stuck_o
);

    // Link is established only when up and no longer training.
    always_comb begin
        up_ok_o = link_up_i && !in_training_i;
        stuck_o = (ltssm_state_i == STUCK_CODE) && !rx_valid_i;
    end

endmodule

// File: rtl/lts_interval_timer.sv
module lts_interval_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lts_attempt_counter.sv
module lts_attempt_counter #(
    parameter int unsigned MAX_TRIES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic last_o
);

    localparam int unsigned CW = $clog2(MAX_TRIES + 1);

    logic [CW-1:0] tries_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries_q <= '0;
        end else if (clear_i) begin
            tries_q <= '0;
        end else if (inc_i && tries_q != CW'(MAX_TRIES - 1)) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign last_o = (tries_q == CW'(MAX_TRIES - 1));

    // R8: the count never runs past the budget
    a_r8_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tries_q <= CW'(MAX_TRIES - 1));

endmodule

// File: rtl/lts_override_mux.sv
module lts_override_mux #(
    parameter int unsigned W        = 16,
    parameter int unsigned DATA_BIT = 5,
    parameter int unsigned PLL_BIT  = 3
) (
    input  logic         pulse_i,
    input  logic [W-1:0] base_i,
    output logic [W-1:0] word_o
);

    localparam logic [W-1:0] MASK = (W'(1) << DATA_BIT) | (W'(1) << PLL_BIT);

    // Read-modify-write: only the two override bits are touched.
    always_comb begin
        if (pulse_i) begin
            word_o = base_i | MASK;
        end else begin
            word_o = base_i & ~MASK;
        end
    end

endmodule

// File: rtl/link_train_supervisor.sv
module link_train_supervisor
    import lts_pkg::*;
#(
    parameter int unsigned CLK_HZ      = 50_000_000,
    parameter int unsigned POLL_US     = 10,
    parameter int unsigned KICK_US     = 3000,
    parameter int unsigned MAX_TRIES   = 4000,
    parameter int unsigned STATE_W     = 6,
    parameter logic [5:0]  STUCK_CODE  = 6'h0D,
    parameter int unsigned OVR_W       = 16,
    parameter int unsigned DATA_BIT    = 5,
    parameter int unsigned PLL_BIT     = 3,
    parameter int unsigned CFG_W       = 16,
    parameter int unsigned SPEED_W     = 4,
    parameter int unsigned SPEED_GEN1  = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               link_up_i,
    input  logic               in_training_i,
    input  logic [STATE_W-1:0] ltssm_state_i,
    input  logic               rx_valid_i,
    input  logic [OVR_W-1:0]   ovr_base_i,
    input  logic [CFG_W-1:0]   speed_cfg_i,
    output logic               train_en_o,
    output logic [CFG_W-1:0]   speed_cfg_o,
    output logic [OVR_W-1:0]   ovr_word_o,
    output logic               rx_data_en_ovr_o,
    output logic               rx_pll_en_ovr_o,
    output logic               link_good_o,
    output logic               link_fail_o
);

    localparam int unsigned CYC_PER_US = (CLK_HZ / US_PER_S) > 0 ? (CLK_HZ / US_PER_S) : 1;
    localparam int unsigned POLL_RAW   = CYC_PER_US * POLL_US;
    localparam int unsigned KICK_RAW   = CYC_PER_US * KICK_US;
    localparam int unsigned POLL_CYC   = POLL_RAW > 0 ? POLL_RAW : 1;
    localparam int unsigned KICK_CYC   = KICK_RAW > 0 ? KICK_RAW : 1;
    localparam int unsigned LONGEST    = KICK_CYC > POLL_CYC ? KICK_CYC : POLL_CYC;
    localparam int unsigned TMR_W      = $clog2(LONGEST + 1);
    localparam int unsigned LEN_W      = TMR_W + 1;

    lts_state_e state_q, state_d;

    logic             up_ok, stuck;
    logic             tmr_load, tmr_expired;
    logic [TMR_W-1:0] tmr_val;
    logic             tries_clr, tries_inc, tries_last;
    logic             speed_forced_q;
    logic             pulse;

    lts_status_decode #(
        .STATE_W    (STATE_W),
        .STUCK_CODE (STUCK_CODE)
    ) u_decode (
        .link_up_i     (link_up_i),
        .in_training_i (in_training_i),
        .ltssm_state_i (ltssm_state_i),
        .rx_valid_i    (rx_valid_i),
        .up_ok_o       (up_ok),
        .stuck_o       (stuck)
    );

    lts_interval_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    lts_attempt_counter #(
        .MAX_TRIES (MAX_TRIES)
    ) u_tries (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tries_clr),
        .inc_i   (tries_inc),
        .last_o  (tries_last)
    );

    lts_override_mux #(
        .W        (OVR_W),
        .DATA_BIT (DATA_BIT),
        .PLL_BIT  (PLL_BIT)
    ) u_ovr (
        .pulse_i (pulse),
        .base_i  (ovr_base_i),
        .word_o  (ovr_word_o)
    );

    // Next-state and sequencing controls
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        tries_clr = 1'b0;
        tries_inc = 1'b0;
        if (start_i) begin
            state_d   = ST_SPEED;
            tries_clr = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_SPEED: state_d = ST_CHECK;
                ST_CHECK: begin
                    if (up_ok) begin
                        state_d = ST_GOOD;
                    end else if (stuck) begin
                        state_d  = ST_KICK;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(KICK_CYC - 1);
                    end else begin
                        state_d  = ST_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(POLL_CYC - 1);
                    end
                end
                ST_KICK: begin
                    if (tmr_expired) begin
                        state_d  = ST_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = TMR_W'(POLL_CYC - 1);
                    end
                end
                ST_WAIT: begin
                    if (tmr_expired) begin
                        if (tries_last) begin
                            state_d = ST_FAIL;
                        end else begin
                            state_d   = ST_CHECK;
                            tries_inc = 1'b1;
                        end
                    end
                end
                ST_GOOD:  state_d = ST_GOOD;
                ST_FAIL:  state_d = ST_FAIL;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Target-speed field is pinned from the start request onward
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed_forced_q <= 1'b0;
        end else if (start_i) begin
            speed_forced_q <= 1'b1;
        end
    end

    // Outputs from the current state
    always_comb begin
        train_en_o       = 1'b0;
        pulse            = 1'b0;
        link_good_o      = 1'b0;
        link_fail_o      = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SPEED: ;
            ST_CHECK, ST_WAIT: train_en_o = 1'b1;
            ST_KICK: begin
                train_en_o = 1'b1;
                pulse      = 1'b1;
            end
            ST_GOOD: begin
                train_en_o  = 1'b1;
                link_good_o = 1'b1;
            end
            ST_FAIL:  link_fail_o = 1'b1;
            default: ;
        endcase
        rx_data_en_ovr_o = ovr_word_o[DATA_BIT];
        rx_pll_en_ovr_o  = ovr_word_o[PLL_BIT];
        speed_cfg_o      = speed_cfg_i;
        if (speed_forced_q) begin
            speed_cfg_o[SPEED_W-1:0] = SPEED_W'(SPEED_GEN1);
        end
    end

    // Pulse-length observer for the R5 window check
    logic [LEN_W-1:0] kick_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kick_len_q <= '0;
        end else if (rx_data_en_ovr_o) begin
            kick_len_q <= kick_len_q + 1'b1;
        end else begin
            kick_len_q <= '0;
        end
    end

    a_r5_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_data_en_ovr_o) |-> (kick_len_q == LEN_W'(KICK_CYC)) || $past(start_i));

    a_r5_kick_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_data_en_ovr_o) |-> $past(ltssm_state_i == STUCK_CODE && !rx_valid_i));

    a_r7_pins_paired: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_en_ovr_o == rx_pll_en_ovr_o);

    a_r3_good_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_good_o) |-> $past(link_up_i && !in_training_i));

    a_r3_good_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        link_good_o && !start_i |=> link_good_o);

    a_r2_speed_before_train: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(train_en_o) |-> $past(speed_cfg_o[SPEED_W-1:0] == SPEED_W'(SPEED_GEN1)));

    a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail_o && !start_i |=> link_fail_o && !train_en_o);

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_good_o && link_fail_o));

    a_r9_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !link_good_o && !link_fail_o && !rx_data_en_ovr_o);

endmodule

// File: tb/link_train_supervisor_tb_top.sv
module link_train_supervisor_tb_top;

    localparam int CLK_HZ = 1_000_000;
    localparam int POLL   = 10;
    localparam int KICK   = 30;
    localparam int TRIES  = 4;
    localparam int STEP   = 1 + POLL;
    localparam logic [15:0] MASK = 16'h0028;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        link_up_i = 1'b0;
    logic        in_training_i = 1'b0;
    logic [5:0]  ltssm_state_i = 6'h00;
    logic        rx_valid_i = 1'b0;
    logic [15:0] ovr_base_i = 16'h1234;
    logic [15:0] speed_cfg_i = 16'hABCD;
    logic        train_en_o;
    logic [15:0] speed_cfg_o;
    logic [15:0] ovr_word_o;
    logic        rx_data_en_ovr_o;
    logic        rx_pll_en_ovr_o;
    logic        link_good_o;
    logic        link_fail_o;

    always #10 clk = ~clk;

    link_train_supervisor #(
        .CLK_HZ    (CLK_HZ),
        .POLL_US   (POLL),
        .KICK_US   (KICK),
        .MAX_TRIES (TRIES)
    ) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .start_i          (start_i),
        .link_up_i        (link_up_i),
        .in_training_i    (in_training_i),
        .ltssm_state_i    (ltssm_state_i),
        .rx_valid_i       (rx_valid_i),
        .ovr_base_i       (ovr_base_i),
        .speed_cfg_i      (speed_cfg_i),
        .train_en_o       (train_en_o),
        .speed_cfg_o      (speed_cfg_o),
        .ovr_word_o       (ovr_word_o),
        .rx_data_en_ovr_o (rx_data_en_ovr_o),
        .rx_pll_en_ovr_o  (rx_pll_en_ovr_o),
        .link_good_o      (link_good_o),
        .link_fail_o      (link_fail_o)
    );

    typedef enum int { EV_KICK, EV_GOOD, EV_FAIL } ev_kind_e;
    typedef struct {
        ev_kind_e kind;
        int       value;
        logic [15:0] word;
        string    req;
    } ev_t;

    ev_t exp_q[$];
    int  n_checks = 0;
    int  n_fails  = 0;
    int  since    = 0;

    always @(posedge clk) begin
        if (start_i) since <= 0;
        else         since <= since + 1;
    end

    task automatic check_val(string req, string what, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
        end
    endtask

    task automatic push(ev_kind_e k, int v, logic [15:0] w, string req);
        ev_t e;
        e.kind = k; e.value = v; e.word = w; e.req = req;
        exp_q.push_back(e);
    endtask

    // Monitor: turns port activity into events and scores them
    task automatic score(ev_kind_e k, int v, logic [15:0] w);
        ev_t e;
        n_checks++;
        if (exp_q.size() == 0) begin
            n_fails++;
            $display("FAIL unexpected event kind %0d value %0d: actual event expected none", k, v);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != k || e.value != v || (k == EV_KICK && e.word != w)) begin
                n_fails++;
                $display("FAIL %s event: actual kind %0d value %0d word 0x%0h expected kind %0d value %0d word 0x%0h",
                         e.req, k, v, w, e.kind, e.value, e.word);
            end
        end
    endtask

    logic        prev_good = 1'b0, prev_fail = 1'b0, prev_kick = 1'b0;
    int          klen = 0;
    logic [15:0] kword = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (link_good_o && !prev_good) score(EV_GOOD, since, 16'h0);
            if (link_fail_o && !prev_fail) score(EV_FAIL, since, 16'h0);
            if (rx_data_en_ovr_o) begin
                klen++;
                kword = ovr_word_o;
                if (rx_pll_en_ovr_o !== 1'b1) begin
                    n_checks++; n_fails++;
                    $display("FAIL R5 pll override: actual %0b expected 1", rx_pll_en_ovr_o);
                end
            end else if (prev_kick) begin
                score(EV_KICK, klen, kword);
                klen = 0;
            end
            prev_good = link_good_o;
            prev_fail = link_fail_o;
            prev_kick = rx_data_en_ovr_o;
        end
    end

    // Driver helpers
    task automatic set_link(logic up, logic trn, logic [5:0] st, logic rxv);
        link_up_i = up; in_training_i = trn; ltssm_state_i = st; rx_valid_i = rxv;
    endtask

    task automatic do_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_since(int n);
        while (since != n) @(negedge clk);
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (5) @(negedge clk);
        check_val("R8", "pending events", exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                n_checks++; n_fails++;
                $display("FAIL R8 watchdog: actual timeout expected completion");
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_val("R1", "good", link_good_o, 0);
        check_val("R1", "fail", link_fail_o, 0);
        check_val("R1", "train_en", train_en_o, 0);
        check_val("R1", "override", rx_data_en_ovr_o, 0);
        check_val("R1", "speed word", speed_cfg_o, 16'hABCD);
        check_val("R1", "ovr word", ovr_word_o, 16'h1234 & ~MASK);

        // R2, R3: link established at the first check
        set_link(1'b1, 1'b0, 6'h11, 1'b1);
        push(EV_GOOD, 2, 16'h0, "R3");
        do_start();
        check_val("R2", "speed word at E", speed_cfg_o, 16'hABC1);
        check_val("R2", "train_en at E", train_en_o, 0);
        @(negedge clk);
        check_val("R2", "train_en at E+1", train_en_o, 1);
        drain();
        set_link(1'b0, 1'b1, 6'h0D, 1'b0);
        repeat (20) @(negedge clk);
        check_val("R3", "good sticky", link_good_o, 1);

        // R4: up but training; R9 start clears good
        set_link(1'b1, 1'b1, 6'h11, 1'b1);
        push(EV_FAIL, 1 + TRIES * STEP, 16'h0, "R8");
        do_start();
        check_val("R9", "good cleared", link_good_o, 0);
        drain();
        repeat (20) @(negedge clk);
        check_val("R8", "fail sticky", link_fail_o, 1);
        check_val("R8", "train_en off", train_en_o, 0);
        check_val("R10", "not both", link_good_o, 0);

        // R4 link down, R6 stuck state with valid data
        set_link(1'b0, 1'b0, 6'h0D, 1'b1);
        push(EV_FAIL, 1 + TRIES * STEP, 16'h0, "R6");
        do_start();
        check_val("R9", "fail cleared", link_fail_o, 0);
        drain();

        // R6 neighbouring state without valid data
        set_link(1'b0, 1'b1, 6'h0C, 1'b0);
        push(EV_FAIL, 1 + TRIES * STEP, 16'h0, "R6");
        do_start();
        drain();

        // R5, R7: stuck on every attempt
        set_link(1'b0, 1'b1, 6'h0D, 1'b0);
        for (int i = 0; i < TRIES; i++) push(EV_KICK, KICK, 16'h123C, "R5");
        push(EV_FAIL, 1 + TRIES * (STEP + KICK), 16'h0, "R8");
        do_start();
        @(negedge clk);
        check_val("R7", "word before pulse", ovr_word_o, 16'h1214);
        wait_since(3);
        check_val("R7", "word during pulse", ovr_word_o, 16'h123C);
        wait_since(2 + KICK);
        check_val("R7", "word after pulse", ovr_word_o, 16'h1214);
        drain();

        // R5 then R3: stuck clears during the pulse
        set_link(1'b0, 1'b1, 6'h0D, 1'b0);
        push(EV_KICK, KICK, 16'h123C, "R5");
        push(EV_GOOD, 2 + STEP + KICK, 16'h0, "R3");
        do_start();
        wait_since(10);
        set_link(1'b1, 1'b0, 6'h11, 1'b1);
        drain();

        // R9 restart while polling
        set_link(1'b0, 1'b0, 6'h11, 1'b1);
        push(EV_FAIL, 1 + TRIES * STEP, 16'h0, "R9");
        do_start();
        wait_since(20);
        do_start();
        drain();

        // R9 restart during a pulse cuts it short
        set_link(1'b0, 1'b1, 6'h0D, 1'b0);
        push(EV_KICK, 9, 16'h123C, "R9");
        push(EV_GOOD, 2, 16'h0, "R9");
        do_start();
        wait_since(10);
        set_link(1'b1, 1'b0, 6'h11, 1'b1);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        check_val("R9", "override cleared", rx_data_en_ovr_o, 0);
        drain();

        finish_run();
    end

endmodule